// File: doc/BRIEF.md
# Palette entry color converter

The block turns raw palette words into a common color word: one transparency flag plus 8 bits each of red, green and blue. It supports four packed entry layouts, picked by a 2-bit format input, and a monochrome mode that copies one byte into all three color channels. A load starts with a pulse on `start_i`. The pixel depth code sets how many entries follow. The entries then arrive on a valid/ready stream and are converted as they come in. Each converted entry is written to an internal palette RAM at its entry number.

The block also keeps a copy of every raw word it accepts. When the format input later differs from the format used for the last conversion, the block walks that raw copy and converts every loaded entry again, one entry per cycle, with no new fetch. A synchronous read port returns the converted word for an index one cycle after the index is presented. Fetching the entries from memory and looking up pixels are done elsewhere.

Top module: `pal_conv`

## Requirements
- R1: Reset state. After reset `in_ready_o` is 0 and `rd_data_o` is 0. The stored format is 0 and no entries count as loaded. A format change before any load therefore writes nothing and does not raise `in_ready_o`.
- R2: Entry count. A `start_i` pulse with `depth_i` equal to 1, 2 or 3 accepts exactly 4, 16 or 256 entries, into indices 0 upwards. `in_ready_o` is 1 from the cycle after the pulse and falls after the last handshake. Any other depth code leaves `in_ready_o` at 0, writes no entry, and leaves nothing loaded for later reconversion.
- R3: The output word has the transparency flag at bit 24, red at bits 23:16, green at bits 15:8 and blue at bits 7:0. Format 0 reads a 16-bit entry from input bits 15:0. It takes red from bits 15:11, green from bits 10:5 and blue from bits 4:0, and places each field at the top of its output byte with zero fill.
- R4: Format 1 reads a 32-bit entry. It takes red from bits 23:19, green from bits 15:10 and blue from bits 7:3, each placed at the top of its output byte with zero fill.
- R5: Format 2 reads a 32-bit entry with three 6-bit fields: red from bits 23:18, green from bits 15:10 and blue from bits 7:2, each placed at the top of its output byte with zero fill.
- R6: Format 3 reads a 32-bit entry with full bytes: red from bits 23:16, green from bits 15:8 and blue from bits 7:0.
- R7: In formats 1, 2 and 3 the output flag copies entry bit 24. In format 0 the flag is always 0.
- R8: When `mono_i` is 1 at conversion time, red, green and blue all equal entry bits 7:0, whatever the format. The flag still follows R7.
- R9: A load converts with the format sampled on its `start_i` cycle. Whenever the block is idle and `fmt_i` differs from the stored format, it stores the new format and reconverts every entry of the last load from the raw copy. This takes at most count+2 cycles. `in_ready_o` stays 0 during the walk. A format change during a load takes effect once the load is complete.
- R10: A change of `mono_i` alone causes no reconversion. Stored entries keep their values.
- R11: `rd_data_o` shows the entry addressed by `rd_idx_i` one clock edge after the index is applied. Back-to-back indices are served one per cycle.
- R12: `start_i` restarts a load from index 0 in any state and takes priority over a pending reconversion. Entries not rewritten keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a palette load |
| depth_i | input | 3 | Pixel depth code: 1, 2 or 3 select 4, 16 or 256 entries |
| fmt_i | input | 2 | Entry layout selector |
| mono_i | input | 1 | Copy the low byte to all three channels |
| in_valid_i | input | 1 | Raw entry valid |
| in_ready_o | output | 1 | Block accepts a raw entry |
| in_data_i | input | 32 | Raw entry; format 0 uses bits 15:0 |
| rd_idx_i | input | 8 | Palette read index |
| rd_data_o | output | 25 | Converted entry {flag, R, G, B} |

## Verification
An accepted entry is written at the handshake edge. Its converted value can therefore be read by applying the index on the next cycle and sampling one edge later. The bench samples each read exactly one edge after setting the index. For R11 it also checks that the previous value is still present before that edge. After a format change, the reconversion finishes within count+2 cycles. The bench waits count+6 cycles before reading back, and reads every loaded entry plus entries outside the loaded range. All inputs are driven and all outputs sampled 1 ns after the rising edge, away from the edge itself.

// File: rtl/pal_conv_pkg.sv
package pal_conv_pkg;

  localparam int RAW_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SWEEP = 2'd2
  } ctrl_st_e;

  typedef struct packed {
    logic       transp;
    logic [7:0] red;
    logic [7:0] grn;
    logic [7:0] blu;
  } pal_rgb_t;

  localparam int PAL_W = $bits(pal_rgb_t);

endpackage

// File: rtl/pal_conv_unpack.sv
module pal_conv_unpack
  import pal_conv_pkg::*;
#(
  parameter int RAW_BITS = RAW_W
) (
  input  logic [RAW_BITS-1:0] raw_i,
  input  logic [1:0]          fmt_i,
  input  logic                mono_i,
  output pal_rgb_t            rgb_o
);

  logic unused_hi;
  assign unused_hi = ^raw_i[RAW_BITS-1:25];

  always_comb begin
    rgb_o = '0;
    unique case (fmt_i)
      2'd0: begin
        rgb_o.red = {raw_i[15:11], 3'b000};
        rgb_o.grn = {raw_i[10:5],  2'b00};
        rgb_o.blu = {raw_i[4:0],   3'b000};
      end
      2'd1: begin
        rgb_o.red = {raw_i[23:19], 3'b000};
        rgb_o.grn = {raw_i[15:10], 2'b00};
        rgb_o.blu = {raw_i[7:3],   3'b000};
      end
      2'd2: begin
        rgb_o.red = {raw_i[23:18], 2'b00};
        rgb_o.grn = {raw_i[15:10], 2'b00};
        rgb_o.blu = {raw_i[7:2],   2'b00};
      end
      default: begin
        rgb_o.red = raw_i[23:16];
        rgb_o.grn = raw_i[15:8];
        rgb_o.blu = raw_i[7:0];
      end
    endcase
    if (mono_i) begin
      rgb_o.red = raw_i[7:0];
      rgb_o.grn = raw_i[7:0];
      rgb_o.blu = raw_i[7:0];
    end
    // flag only exists in the 32-bit layouts
    rgb_o.transp = (fmt_i != 2'd0) && raw_i[24];
  end

endmodule

// File: rtl/pal_conv_ram.sv
module pal_conv_ram #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/pal_conv_ctrl.sv
module pal_conv_ctrl
  import pal_conv_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       depth_i,
  input  logic [1:0]       fmt_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic [1:0]       fmt_used_o,
  output logic [CNT_W-1:0] load_cnt_o,
  output logic             raw_we_o,
  output logic [IDX_W-1:0] raw_waddr_o,
  output logic [IDX_W-1:0] raw_raddr_o,
  output logic             sweep_wr_o,
  output logic             pal_we_o,
  output logic [IDX_W-1:0] pal_waddr_o
);

  ctrl_st_e         st_q;
  logic [CNT_W-1:0] idx_q, cnt_q, cnt_new;
  logic [1:0]       fmt_q;
  logic             rd_vld_q;
  logic [IDX_W-1:0] rd_widx_q;
  logic             accept, last;

  always_comb begin
    unique case (depth_i)
      3'd1:    cnt_new = CNT_W'(4);
      3'd2:    cnt_new = CNT_W'(16);
      3'd3:    cnt_new = CNT_W'(1) << 8;
      default: cnt_new = '0;
    endcase
  end

  assign accept = (st_q == ST_LOAD) && in_valid_i;
  assign last   = (idx_q == cnt_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      fmt_q     <= '0;
      rd_vld_q  <= 1'b0;
      rd_widx_q <= '0;
    end else if (start_i) begin
      cnt_q    <= cnt_new;
      fmt_q    <= fmt_i;
      idx_q    <= '0;
      rd_vld_q <= 1'b0;
      st_q     <= (cnt_new != '0) ? ST_LOAD : ST_IDLE;
    end else begin
      rd_vld_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (fmt_i != fmt_q) begin
            fmt_q <= fmt_i;
            if (cnt_q != '0) begin
              st_q  <= ST_SWEEP;
              idx_q <= '0;
            end
          end
        end
        ST_LOAD: begin
          if (accept) begin
            idx_q <= idx_q + CNT_W'(1);
            if (last) st_q <= ST_IDLE;
          end
        end
        default: begin
          // raw read issued now, converted write lands next cycle
          rd_vld_q  <= 1'b1;
          rd_widx_q <= idx_q[IDX_W-1:0];
          idx_q     <= idx_q + CNT_W'(1);
          if (last) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign in_ready_o  = (st_q == ST_LOAD);
  assign fmt_used_o  = fmt_q;
  assign load_cnt_o  = cnt_q;
  assign raw_we_o    = accept;
  assign raw_waddr_o = idx_q[IDX_W-1:0];
  assign raw_raddr_o = idx_q[IDX_W-1:0];
  assign sweep_wr_o  = rd_vld_q;
  assign pal_we_o    = accept | rd_vld_q;
  assign pal_waddr_o = rd_vld_q ? rd_widx_q : idx_q[IDX_W-1:0];

endmodule

// File: rtl/pal_conv.sv
module pal_conv
  import pal_conv_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int RAW_BITS = RAW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2:0]          depth_i,
  input  logic [1:0]          fmt_i,
  input  logic                mono_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [RAW_BITS-1:0] in_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [PAL_W-1:0]    rd_data_o
);

  localparam int CNT_W = IDX_W + 1;

  logic [1:0]          fmt_used;
  logic [CNT_W-1:0]    load_cnt;
  logic                raw_we, sweep_wr, pal_we;
  logic [IDX_W-1:0]    raw_waddr, raw_raddr, pal_waddr;
  logic [RAW_BITS-1:0] raw_rdata, conv_raw;
  pal_rgb_t            pal_wdata;

  pal_conv_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .depth_i     (depth_i),
    .fmt_i       (fmt_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .fmt_used_o  (fmt_used),
    .load_cnt_o  (load_cnt),
    .raw_we_o    (raw_we),
    .raw_waddr_o (raw_waddr),
    .raw_raddr_o (raw_raddr),
    .sweep_wr_o  (sweep_wr),
    .pal_we_o    (pal_we),
    .pal_waddr_o (pal_waddr)
  );

  pal_conv_ram #(.W(RAW_BITS), .AW(IDX_W)) u_raw_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (raw_we),
    .waddr_i (raw_waddr),
    .wdata_i (in_data_i),
    .raddr_i (raw_raddr),
    .rdata_o (raw_rdata)
  );

  assign conv_raw = sweep_wr ? raw_rdata : in_data_i;

  pal_conv_unpack #(.RAW_BITS(RAW_BITS)) u_unpack (
    .raw_i  (conv_raw),
    .fmt_i  (fmt_used),
    .mono_i (mono_i),
    .rgb_o  (pal_wdata)
  );

  pal_conv_ram #(.W(PAL_W), .AW(IDX_W)) u_pal_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we),
    .waddr_i (pal_waddr),
    .wdata_i (pal_wdata),
    .raddr_i (rd_idx_i),
    .rdata_o (rd_data_o)
  );

endmodule

// File: rtl/pal_conv_chk.sv
module pal_conv_chk #(
  parameter int IDX_W = 8,
  parameter int CNT_W = IDX_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [2:0]       depth_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             pal_we,
  input logic [IDX_W-1:0] pal_waddr,
  input logic [24:0]      pal_wdata,
  input logic             sweep_wr,
  input logic [1:0]       fmt_used,
  input logic [CNT_W-1:0] load_cnt
);

  // R12
  ready_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (depth_i inside {3'd1, 3'd2, 3'd3}) |=> in_ready_o);

  // R2
  no_ready_bad_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !(depth_i inside {3'd1, 3'd2, 3'd3}) |=> !in_ready_o);

  // R2
  ready_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |-> $past(in_valid_i) || $past(start_i));

  // R2
  waddr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we |-> ({1'b0, pal_waddr} < load_cnt));

  // R9
  no_wr_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !sweep_wr);

  // R7
  opaque_fmt0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we && (fmt_used == 2'd0) |-> !pal_wdata[24]);

endmodule

bind pal_conv pal_conv_chk #(.IDX_W(IDX_W), .CNT_W(IDX_W + 1)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .depth_i    (depth_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .pal_we     (pal_we),
  .pal_waddr  (pal_waddr),
  .pal_wdata  (pal_wdata),
  .sweep_wr   (sweep_wr),
  .fmt_used   (fmt_used),
  .load_cnt   (load_cnt)
);

// File: tb/pal_conv_bench.sv
module pal_conv_bench;

  localparam int CLK_P = 10;
  localparam int N     = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  depth_i = '0;
  logic [1:0]  fmt_i = '0;
  logic        mono_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic [7:0]  rd_idx_i = '0;
  logic [24:0] rd_data_o;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] raw_m [N];
  logic [24:0] exp_m [N];
  int          cur_n = 0;
  int          wr_idx = 0;
  logic [1:0]  cur_fmt = '0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  pal_conv u_pal_conv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .depth_i    (depth_i),
    .fmt_i      (fmt_i),
    .mono_i     (mono_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (rd_data_o)
  );

  function automatic logic [24:0] model(logic [31:0] w, logic [1:0] f, logic m);
    int unsigned v, r, g, b, t;
    v = w;
    t = (f != 2'd0) ? ((v >> 24) & 1) : 0;
    case (f)
      2'd0: begin r = ((v >> 11) & 31) * 8; g = ((v >> 5) & 63) * 4; b = (v & 31) * 8; end
      2'd1: begin r = ((v >> 19) & 31) * 8; g = ((v >> 10) & 63) * 4; b = ((v >> 3) & 31) * 8; end
      2'd2: begin r = ((v >> 18) & 63) * 4; g = ((v >> 10) & 63) * 4; b = ((v >> 2) & 63) * 4; end
      default: begin r = (v >> 16) & 255; g = (v >> 8) & 255; b = v & 255; end
    endcase
    if (m) begin r = v & 255; g = r; b = r; end
    return 25'(t * 32'h0100_0000 + r * 32'h1_0000 + g * 32'h100 + b);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic start_load(logic [2:0] d, logic [1:0] f);
    start_i = 1'b1; depth_i = d; fmt_i = f;
    tick();
    start_i = 1'b0;
    cur_n   = (d == 3'd1) ? 4 : (d == 3'd2) ? 16 : (d == 3'd3) ? 256 : 0;
    cur_fmt = f;
    wr_idx  = 0;
  endtask

  task automatic push(logic [31:0] d);
    in_valid_i = 1'b1; in_data_i = d;
    while (!in_ready_o) tick();
    tick();
    in_valid_i = 1'b0;
    raw_m[wr_idx] = d;
    exp_m[wr_idx] = model(d, cur_fmt, mono_i);
    wr_idx++;
  endtask

  task automatic set_fmt(logic [1:0] f);
    fmt_i = f;
    if (f != cur_fmt) begin
      cur_fmt = f;
      for (int i = 0; i < cur_n; i++) exp_m[i] = model(raw_m[i], f, mono_i);
    end
    repeat (cur_n + 6) tick();
  endtask

  task automatic read_range(int lo, int hi, string tag);
    for (int i = lo; i < hi; i++) begin
      rd_idx_i = 8'(i);
      tick();
      check(tag, {7'd0, rd_data_o}, {7'd0, exp_m[i]});
    end
  endtask

  function automatic logic [31:0] pat(int i, int s);
    return (32'(i) * 32'h9E37_79B1) ^ (32'(s) * 32'h85EB_CA6B) ^ 32'(i << 24);
  endfunction

  task automatic load_n(int n, int s);
    for (int i = 0; i < n; i++) begin
      push(pat(i, s));
      if ((i % 7) == 3) tick();
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    // R1 reset state
    check("R1 ready", 32'(in_ready_o), 0);
    check("R1 rd_data", {7'd0, rd_data_o}, 0);
    set_fmt(2'd2);
    check("R1 no load after fmt change", 32'(in_ready_o), 0);
    set_fmt(2'd0);

    // R2 256 entries, R3 format 0, R7 flag forced 0
    start_load(3'd3, 2'd0);
    check("R2 ready after start", 32'(in_ready_o), 1);
    load_n(256, 1);
    check("R2 ready drops after 256", 32'(in_ready_o), 0);
    read_range(0, 256, "R3 R7 format0");

    // R9 reconversion into each 32-bit layout
    set_fmt(2'd1);
    read_range(0, 256, "R4 R7 R9 format1");
    set_fmt(2'd2);
    read_range(0, 256, "R5 R7 R9 format2");
    set_fmt(2'd3);
    read_range(0, 256, "R6 R7 R9 format3");

    // R10 mono change alone does nothing
    mono_i = 1'b1;
    repeat (270) tick();
    read_range(0, 64, "R10 mono no rewrite");
    // R8 mono applied on the next reconversion
    set_fmt(2'd0);
    read_range(0, 256, "R8 mono format0");
    set_fmt(2'd3);
    read_range(0, 256, "R8 mono format3");
    mono_i = 1'b0;

    // R2 4 entries
    start_load(3'd1, 2'd3);
    load_n(4, 2);
    check("R2 ready drops after 4", 32'(in_ready_o), 0);
    read_range(0, 8, "R2 depth1");
    set_fmt(2'd1);
    read_range(0, 8, "R9 sweep limited to 4");
    read_range(200, 204, "R9 beyond count untouched");

    // R2 16 entries
    start_load(3'd2, 2'd2);
    load_n(16, 3);
    check("R2 ready drops after 16", 32'(in_ready_o), 0);
    read_range(0, 20, "R2 depth2");

    // R2 unsupported depth codes
    start_load(3'd0, 2'd0);
    repeat (4) tick();
    check("R2 depth0 no ready", 32'(in_ready_o), 0);
    start_load(3'd5, 2'd3);
    check("R2 depth5 no ready", 32'(in_ready_o), 0);
    set_fmt(2'd1);
    repeat (20) tick();
    read_range(0, 20, "R2 no conversion");

    // R12 restart mid-load
    start_load(3'd2, 2'd2);
    load_n(5, 4);
    start_load(3'd1, 2'd3);
    check("R12 ready after restart", 32'(in_ready_o), 1);
    load_n(4, 5);
    check("R12 ready drops after 4", 32'(in_ready_o), 0);
    read_range(0, 16, "R12 restart");

    // R9 format change during a load
    start_load(3'd2, 2'd1);
    load_n(8, 6);
    fmt_i = 2'd3;
    for (int i = 8; i < 16; i++) push(pat(i, 6));
    check("R9 ready drops", 32'(in_ready_o), 0);
    set_fmt(2'd3);
    read_range(0, 16, "R9 mid-load change");

    // R11 one-cycle read latency, back to back
    rd_idx_i = 8'd0;
    tick();
    for (int i = 1; i < 16; i++) begin
      rd_idx_i = 8'(i);
      #1 check("R11 old value before edge", {7'd0, rd_data_o}, {7'd0, exp_m[i-1]});
      tick();
      check("R11 new value after edge", {7'd0, rd_data_o}, {7'd0, exp_m[i]});
    end

    finish_run();
  end

endmodule